// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block is a purely combinational binary adder of parameterised width. It splits the operand width into consecutive blocks. The lowest block is a plain ripple adder of `BASE_W` bits, and every block above it is one bit wider than the block beneath it. Each upper block works out per-bit propagate and generate terms. It then runs two carry chains side by side: one assumes an incoming carry of 0 and the other assumes 1. The true carry leaving the block below steers a 2-to-1 selection of the carry vector and carry-out. The block's sum bits are then formed from its propagate terms and the selected carry vector.

Because the blocks widen as they go up, each selection carry arrives at about the moment the candidate results of the next block are ready. If the growing widths would run past `WIDTH`, the topmost block is cut short so that the block widths add up to exactly `WIDTH`. An elaboration-time check stops the build if they do not. The block is used wherever a datapath needs an add that is faster than a single ripple chain but more regular than full lookahead.

Top module: `sqcs_adder`

## Requirements
- R1: `sum` equals the low `WIDTH` bits of `op_a + op_b + carry_in`, treating all values as unsigned, for every operand pair and both carry-in values.
- R2: `carry_out` equals bit `WIDTH` of the unsigned total `op_a + op_b + carry_in`.
- R3: The lowest block covers bits `0` to `BASE_W-1`, and block k covers the next `BASE_W+k` bits. The topmost block is shortened so that the widths add up to `WIDTH` (for example, 32 bits with a base of 4 give blocks of 4, 5, 6, 7, 8 and 2 bits). A carry that starts just below any block boundary reaches the bits above that boundary.
- R4: The carry leaving each block equals the carry out of the unsigned addition of all operand bits up to and including that block's top bit, plus `carry_in`.
- R5: When every bit of a block has `op_a` differing from `op_b`, the block passes its incoming carry unchanged to its outgoing carry.
- R6: The lowest block ripples straight from `carry_in`, so bit 0 of `sum` is `op_a[0] ^ op_b[0] ^ carry_in`.
- R7: The result depends only on the current inputs. The block has no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is a carry that is generated just below a block boundary and then has to cross every block above it through a run of propagating bits. Only then does each select multiplexer have to pick its carry-in-1 candidate one after another. Random operands almost never make this happen. The bench therefore computes the boundary positions from R3 for each instance. At every boundary it places a generate in the bit just below and all-propagate bits above, and applies each pattern with both carry-in values. This is done for two different base widths, one of which truncates its top block.

// File: rtl/sqcs_pkg.sv
package sqcs_pkg;

    typedef struct packed {
        logic p;
        logic g;
    } pg_bit_t;

    // Number of blocks needed to cover n bits starting at width m.
    function automatic int blk_count(input int n, input int m);
        int tot;
        int cnt;
        tot = 0;
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            if (tot < n) begin
                tot = tot + m + k;
                cnt = cnt + 1;
            end
        end
        return cnt;
    endfunction

    // Lowest bit index of block idx.
    function automatic int blk_lo(input int n, input int m, input int idx);
        int lo;
        lo = idx * m + (idx * (idx - 1)) / 2;
        if (lo > n) lo = n;
        return lo;
    endfunction

    // Width of block idx, the top one trimmed to fit n.
    function automatic int blk_w(input int n, input int m, input int idx);
        int full;
        int rem;
        full = m + idx;
        rem  = n - blk_lo(n, m, idx);
        if (rem < 0) rem = 0;
        return (full < rem) ? full : rem;
    endfunction

    function automatic int width_total(input int n, input int m);
        int tot;
        tot = 0;
        for (int k = 0; k < blk_count(n, m); k++) begin
            tot = tot + blk_w(n, m, k);
        end
        return tot;
    endfunction

endpackage

// File: rtl/sqcs_pg_gen.sv
module sqcs_pg_gen #(
    parameter int W = 4
) (
    input  logic                      [W-1:0] op_a,
    input  logic                      [W-1:0] op_b,
    output sqcs_pkg::pg_bit_t [W-1:0]         pg
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign pg[i].p = op_a[i] ^ op_b[i];
        assign pg[i].g = op_a[i] & op_b[i];
    end
endmodule

// File: rtl/sqcs_carry_chain.sv
module sqcs_carry_chain #(
    parameter int W = 4
) (
    input  sqcs_pkg::pg_bit_t [W-1:0] pg,
    input  logic                      cin,
    output logic              [W:0]   carries
);
    always_comb begin
        carries[0] = cin;
        for (int i = 0; i < W; i++) begin
            carries[i+1] = pg[i].g | (pg[i].p & carries[i]);
        end
    end
endmodule

// File: rtl/sqcs_base_blk.sv
module sqcs_base_blk #(
    parameter int W = 4
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    sqcs_pkg::pg_bit_t [W-1:0] pg;
    logic              [W:0]   cv;
    logic              [W-1:0] prop;

    sqcs_pg_gen #(.W(W)) u_pg (
        .op_a (op_a),
        .op_b (op_b),
        .pg   (pg)
    );

    sqcs_carry_chain #(.W(W)) u_chain (
        .pg      (pg),
        .cin     (cin),
        .carries (cv)
    );

    for (genvar i = 0; i < W; i++) begin : g_prop
        assign prop[i] = pg[i].p;
    end

    assign sum  = prop ^ cv[W-1:0];
    assign cout = cv[W];
endmodule

// File: rtl/sqcs_select_blk.sv
module sqcs_select_blk #(
    parameter int W = 5
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    sqcs_pkg::pg_bit_t [W-1:0] pg;
    logic              [W:0]   cv_zero;
    logic              [W:0]   cv_one;
    logic              [W:0]   cv_sel;
    logic              [W-1:0] prop;

    sqcs_pg_gen #(.W(W)) u_pg (
        .op_a (op_a),
        .op_b (op_b),
        .pg   (pg)
    );

    sqcs_carry_chain #(.W(W)) u_chain_zero (
        .pg      (pg),
        .cin     (1'b0),
        .carries (cv_zero)
    );

    sqcs_carry_chain #(.W(W)) u_chain_one (
        .pg      (pg),
        .cin     (1'b1),
        .carries (cv_one)
    );

    for (genvar i = 0; i < W; i++) begin : g_prop
        assign prop[i] = pg[i].p;
    end

    assign cv_sel = cin ? cv_one : cv_zero;
    assign sum    = prop ^ cv_sel[W-1:0];
    assign cout   = cv_sel[W];
endmodule

// File: rtl/sqcs_adder.sv
module sqcs_adder #(
    parameter int WIDTH  = 32,
    parameter int BASE_W = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    localparam int NB = sqcs_pkg::blk_count(WIDTH, BASE_W);

    logic blk_carry [NB+1];

    if (BASE_W < 1) begin : g_bad_base
        $error("sqcs_adder: BASE_W must be at least 1");
    end
    if (sqcs_pkg::width_total(WIDTH, BASE_W) != WIDTH) begin : g_bad_total
        $error("sqcs_adder: block widths do not add up to WIDTH");
    end

    assign blk_carry[0] = carry_in;

    for (genvar k = 0; k < NB; k++) begin : g_blk
        localparam int LO = sqcs_pkg::blk_lo(WIDTH, BASE_W, k);
        localparam int W  = sqcs_pkg::blk_w(WIDTH, BASE_W, k);
        if (k == 0) begin : g_base
            sqcs_base_blk #(.W(W)) u_blk (
                .op_a (op_a[LO+W-1:LO]),
                .op_b (op_b[LO+W-1:LO]),
                .cin  (blk_carry[k]),
                .sum  (sum[LO+W-1:LO]),
                .cout (blk_carry[k+1])
            );
        end else begin : g_sel
            sqcs_select_blk #(.W(W)) u_blk (
                .op_a (op_a[LO+W-1:LO]),
                .op_b (op_b[LO+W-1:LO]),
                .cin  (blk_carry[k]),
                .sum  (sum[LO+W-1:LO]),
                .cout (blk_carry[k+1])
            );
        end
    end

    assign carry_out = blk_carry[NB];
endmodule

// File: rtl/sqcs_adder_chk.sv
module sqcs_adder_chk #(
    parameter int WIDTH  = 32,
    parameter int BASE_W = 4,
    parameter int NB     = 1
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum,
    input logic             carry_out,
    input logic             blk_carry [NB+1]
);
    logic [WIDTH:0] total;
    assign total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

    always_comb begin
        // R1 and R2: full result against a plain unsigned sum
        p_total_r1: assert ({carry_out, sum} == total)
            else $error("R1/R2 result mismatch");
        // R6: lowest bit ripples straight from carry_in
        p_lsb_r6: assert (sum[0] == (op_a[0] ^ op_b[0] ^ carry_in))
            else $error("R6 bit 0 mismatch");
    end

    for (genvar k = 0; k < NB; k++) begin : g_blk
        localparam int LO = sqcs_pkg::blk_lo(WIDTH, BASE_W, k);
        localparam int HI = LO + sqcs_pkg::blk_w(WIDTH, BASE_W, k) - 1;
        logic [HI+1:0] part;
        assign part = {1'b0, op_a[HI:0]} + {1'b0, op_b[HI:0]} + {{(HI+1){1'b0}}, carry_in};
        always_comb begin
            // R4: selected carry matches the partial-sum carry
            p_blk_carry_r4: assert (blk_carry[k+1] == part[HI+1])
                else $error("R4 block carry mismatch");
            // R5: fully propagating block passes its carry through
            if (&(op_a[HI:LO] ^ op_b[HI:LO])) begin
                p_pass_r5: assert (blk_carry[k+1] == blk_carry[k])
                    else $error("R5 pass-through mismatch");
            end
        end
    end
endmodule

bind sqcs_adder sqcs_adder_chk #(
    .WIDTH  (WIDTH),
    .BASE_W (BASE_W),
    .NB     (sqcs_pkg::blk_count(WIDTH, BASE_W))
) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out),
    .blk_carry (blk_carry)
);

// File: tb/test_sqcs_adder.sv
`timescale 1ns/1ps
module test_sqcs_adder;

    localparam int WA = 32;
    localparam int MA = 4;
    localparam int WB = 16;
    localparam int MB = 3;

    typedef struct packed {
        logic [WA-1:0] a;
        logic [WA-1:0] b;
        logic          cin;
        logic [WA-1:0] s;
        logic          co;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0},
        '{32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_0001, 1'b0},
        '{32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1},
        '{32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b1},
        '{32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 32'hFFFF_FFFF, 1'b0},
        '{32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 32'h0000_0000, 1'b1},
        '{32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1},
        '{32'h1234_5678, 32'h8765_4321, 1'b0, 32'h9999_9999, 1'b0},
        '{32'h0000_000F, 32'h0000_0001, 1'b0, 32'h0000_0010, 1'b0},
        '{32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, 32'h5555_5554, 1'b1},
        '{32'h7FFF_FFFF, 32'h0000_0001, 1'b1, 32'h8000_0001, 1'b0}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [WA-1:0] a_a, b_a, s_a;
    logic          ci_a, co_a;
    logic [WB-1:0] a_b, b_b, s_b;
    logic          ci_b, co_b;

    int checks = 0;
    int fails  = 0;

    sqcs_adder #(.WIDTH(WA), .BASE_W(MA)) i_sqcs_adder (
        .op_a (a_a), .op_b (b_a), .carry_in (ci_a),
        .sum  (s_a), .carry_out (co_a)
    );

    sqcs_adder #(.WIDTH(WB), .BASE_W(MB)) i_sqcs_adder_b (
        .op_a (a_b), .op_b (b_b), .carry_in (ci_b),
        .sum  (s_b), .carry_out (co_b)
    );

    task automatic chk_a(input logic [WA-1:0] a, input logic [WA-1:0] b, input logic ci,
                         input logic [WA-1:0] es, input logic eco, input string req);
        @(posedge clk);
        a_a = a; b_a = b; ci_a = ci;
        @(negedge clk);
        checks++;
        if (s_a !== es || co_a !== eco) begin
            fails++;
            $display("FAIL %s a=%h b=%h ci=%b: actual %b_%h expected %b_%h",
                     req, a, b, ci, co_a, s_a, eco, es);
        end
    endtask

    task automatic ref_a(input logic [WA-1:0] a, input logic [WA-1:0] b, input logic ci,
                         input string req);
        logic [WA:0] t;
        t = {1'b0, a} + {1'b0, b} + {{WA{1'b0}}, ci};
        chk_a(a, b, ci, t[WA-1:0], t[WA], req);
    endtask

    task automatic ref_b(input logic [WB-1:0] a, input logic [WB-1:0] b, input logic ci,
                         input string req);
        logic [WB:0] t;
        t = {1'b0, a} + {1'b0, b} + {{WB{1'b0}}, ci};
        @(posedge clk);
        a_b = a; b_b = b; ci_b = ci;
        @(negedge clk);
        checks++;
        if (s_b !== t[WB-1:0] || co_b !== t[WB]) begin
            fails++;
            $display("FAIL %s a=%h b=%h ci=%b: actual %b_%h expected %b_%h",
                     req, a, b, ci, co_b, s_b, t[WB], t[WB-1:0]);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        a_a = '0; b_a = '0; ci_a = 1'b0;
        a_b = '0; b_b = '0; ci_b = 1'b0;
        seed = 32'h1F2E_3D4C;

        // R7: outputs settle from inputs with no clocked state
        chk_a('0, '0, 1'b0, '0, 1'b0, "R7 idle");

        // R1/R2: table of corner vectors
        for (int i = 0; i < 12; i++) begin
            chk_a(VECS[i].a, VECS[i].b, VECS[i].cin, VECS[i].s, VECS[i].co, "R1/R2 table");
        end

        // R6: bit 0 driven by carry_in alone
        chk_a('0, '0, 1'b1, 32'h1, 1'b0, "R6 cin only");
        ref_b('0, '0, 1'b1, "R6 cin only");
        // R5: all-propagate operands pass the carry through every block
        chk_a(32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b1, 32'h0, 1'b1, "R5 full propagate");
        ref_b(16'hFFFF, 16'h0000, 1'b1, "R5 full propagate");
        ref_b(16'hFFFF, 16'h0001, 1'b0, "R2 all ones plus one");
        ref_b(16'h5555, 16'hAAAA, 1'b0, "R1 alternating");
        ref_b(16'hAAAA, 16'hAAAA, 1'b1, "R1 alternating");

        // R3/R4: carry generated below each block boundary, propagated above
        for (int ci = 0; ci < 2; ci++) begin
            for (int pos = MA, w = MA; pos < WA; w++, pos += w) begin
                logic [WA-1:0] hi_ones;
                hi_ones = '1 << (pos - 1);
                ref_a(hi_ones, 32'h1 << (pos - 1), ci[0], "R3 boundary A");
                ref_a(~hi_ones ^ (32'h1 << pos), hi_ones, ci[0], "R4 boundary A");
            end
            for (int pos = MB, w = MB; pos < WB; w++, pos += w) begin
                logic [WB-1:0] hi_ones;
                hi_ones = '1 << (pos - 1);
                ref_b(hi_ones, 16'h1 << (pos - 1), ci[0], "R3 boundary B");
                ref_b(~hi_ones ^ (16'h1 << pos), hi_ones, ci[0], "R4 boundary B");
            end
        end

        // R1/R2: random operands on both instances, both carry-ins
        for (int i = 0; i < 300; i++) begin
            logic [31:0] ra, rb;
            seed = nxt(seed); ra = seed;
            seed = nxt(seed); rb = seed;
            ref_a(ra, rb, seed[7], "R1/R2 random A");
            ref_b(ra[WB-1:0], rb[WB-1:0], seed[9], "R1/R2 random B");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule